// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a small bank of general-purpose output lines, any of which can serve as a chip select for devices on a serial bus. Each line has a stored state bit, and the level seen on the pin is that state combined with a per-line invert bit. The invert bit lets one line serve an active-high select while its neighbours stay active-low. Software never rewrites the whole bank. It issues a force command that carries one set bit and one clear bit per line, so a line can be selected or released without disturbing any other line and without a read-modify-write.

A configuration word, loaded on its own strobe, marks which lines act as chip selects and which lines are inverted. The serial engine reports activity on a busy input. While a transfer is running, force commands aimed at chip-select lines are held back in a per-line pending slot and take effect in the first cycle the engine is idle. This stops a select from dropping in the middle of a word. Plain outputs are not held back. Selecting a device means clearing its line, and releasing it means setting the line. A status word reports the pin levels and which lines have a deferred command waiting.

Top module: `cs_out_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, every pin is 0, every status bit is 0, and the configuration reads as all zero (no chip-select lines, no inversion).
- R2: Configuration is loaded from `cfg_i` only in a cycle where `cfg_we_i` is 1. Bits N to 2N-1 mark lines 0 to N-1 as chip-select lines. When `cfg_we_i` is 0, changes on `cfg_i` have no effect on the pins.
- R3: Configuration bit n (0 to N-1) inverts line n, so that line n's pin equals its stored state XOR its invert bit.
- R4: In a force command accepted with `frc_we_i`, bit N+n sets the stored state of line n and bit n clears it. The pins show the result one clock after the write.
- R5: A line whose set bit and clear bit are both 1 in the same command keeps its state, and so does a line with neither bit set.
- R6: A force command of 0xFF00 (N=8) sets all eight stored states to 1, so with no inversion every pin goes high.
- R7: While `busy_i` is 1, a force command for a chip-select line does not change that line and is stored as pending. A force command for a plain line takes effect at once.
- R8: A pending command is applied in the first clock edge at which `busy_i` is 0. A newer command to the same line replaces the pending one. A command written in that release cycle wins over the pending one.
- R9: `status_o` bits 0 to N-1 equal the pin levels, and bits N to 2N-1 flag the lines that hold a pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_i | input | 2*NUM_LINES | Chip-select marks (upper half) and invert bits (lower half) |
| frc_we_i | input | 1 | Force command strobe |
| frc_i | input | 2*NUM_LINES | Per-line set bits (upper half) and clear bits (lower half) |
| busy_i | input | 1 | Serial engine is mid-transfer |
| pins_o | output | NUM_LINES | Output pin levels |
| status_o | output | 2*NUM_LINES | Pending flags (upper half) and pin levels (lower half) |

## Verification
The properties on force commands assume that the configuration is not reloaded in the same cycle. The reason is that a changing invert bit would move a pin on its own. The bench therefore never raises `cfg_we_i` together with `frc_we_i`. The deferral property assumes that `busy_i` is sampled at the same edge as the strobe, so the stimulus changes `busy_i` only at the falling edge, together with the command. The bench also walks the two race cases on purpose: a command issued while busy that replaces an earlier pending one, and a command issued in the very cycle that busy falls.

// File: rtl/cso_pkg.sv
package cso_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } req_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } act_e;

  function automatic act_e decode_req(req_t r);
    if (r.set && !r.clr)      return ACT_SET;
    else if (r.clr && !r.set) return ACT_CLR;
    else                      return ACT_HOLD;
  endfunction

endpackage

// File: rtl/cso_cfg_reg.sv
module cso_cfg_reg #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned CW = 2 * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CW-1:0]        cfg_i,
  output logic [NUM_LINES-1:0] inv_o,
  output logic [NUM_LINES-1:0] cs_o
);

  logic [CW-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_i;
  end

  assign inv_o = cfg_q[NUM_LINES-1:0];
  assign cs_o  = cfg_q[CW-1:NUM_LINES];

endmodule

// File: rtl/cso_line_gate.sv
module cso_line_gate
  import cso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_en_i,
  input  logic busy_i,
  input  logic we_i,
  input  req_t req_i,
  output act_e act_o,
  output logic pend_o
);

  req_t pend_q;
  req_t chosen;
  logic has_req, hold, defer, direct, apply_pend;

  assign has_req    = req_i.set | req_i.clr;
  assign hold       = busy_i & cs_en_i;
  assign defer      = we_i & has_req & hold;
  assign direct     = we_i & has_req & ~hold;
  assign apply_pend = ~busy_i & (pend_q.set | pend_q.clr);

  // a fresh command outranks a pending one
  always_comb begin
    if (direct)          chosen = req_i;
    else if (apply_pend) chosen = pend_q;
    else                 chosen = '0;
  end

  assign act_o  = decode_req(chosen);
  assign pend_o = pend_q.set | pend_q.clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= '0;
    else if (defer)                 pend_q <= req_i;
    else if (direct || apply_pend)  pend_q <= '0;
  end

endmodule

// File: rtl/cso_line_state.sv
module cso_line_state
  import cso_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  act_e act_i,
  input  logic inv_i,
  output logic pin_o
);

  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else begin
      case (act_i)
        ACT_SET: state_q <= 1'b1;
        ACT_CLR: state_q <= 1'b0;
        default: state_q <= state_q;
      endcase
    end
  end

  assign pin_o = state_q ^ inv_i;

endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
  import cso_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned CW = 2 * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CW-1:0]        cfg_i,
  input  logic                 frc_we_i,
  input  logic [CW-1:0]        frc_i,
  input  logic                 busy_i,
  output logic [NUM_LINES-1:0] pins_o,
  output logic [CW-1:0]        status_o
);

  logic [NUM_LINES-1:0] inv, cs, pend;

  cso_cfg_reg #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .cfg_i (cfg_i),
    .inv_o (inv),
    .cs_o  (cs)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    req_t req;
    act_e act;

    assign req.set = frc_i[NUM_LINES + n];
    assign req.clr = frc_i[n];

    cso_line_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_en_i(cs[n]),
      .busy_i (busy_i),
      .we_i   (frc_we_i),
      .req_i  (req),
      .act_o  (act),
      .pend_o (pend[n])
    );

    cso_line_state u_state (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act),
      .inv_i (inv[n]),
      .pin_o (pins_o[n])
    );
  end

  assign status_o = {pend, pins_o};

endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned CW = 2 * NUM_LINES
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic                 frc_we_i,
  input logic [CW-1:0]        frc_i,
  input logic                 busy_i,
  input logic [NUM_LINES-1:0] pins_o,
  input logic [CW-1:0]        status_o,
  input logic [NUM_LINES-1:0] inv_i,
  input logic [NUM_LINES-1:0] cs_i
);

  logic [NUM_LINES-1:0] set_w, clr_w, pend_w;
  assign set_w  = frc_i[CW-1:NUM_LINES];
  assign clr_w  = frc_i[NUM_LINES-1:0];
  assign pend_w = status_o[CW-1:NUM_LINES];

  assert_set_applied_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_we_i && !busy_i && !cfg_we_i |=>
      (((pins_o ^ inv_i) & $past(set_w & ~clr_w)) == $past(set_w & ~clr_w)));

  assert_clr_applied_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_we_i && !busy_i && !cfg_we_i |=>
      (((pins_o ^ inv_i) & $past(clr_w & ~set_w)) == '0));

  assert_conflict_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_we_i && !busy_i && !cfg_we_i && (pend_w == '0) |=>
      (((pins_o ^ $past(pins_o)) & $past(set_w & clr_w)) == '0));

  assert_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frc_we_i && !cfg_we_i && (pend_w == '0) |=> $stable(pins_o));

  assert_cs_deferred_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_we_i && busy_i && !cfg_we_i |=>
      (((pins_o ^ $past(pins_o)) & $past(cs_i)) == '0));

  assert_pend_drained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (pend_w == '0));

endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_we_i(cfg_we_i),
  .frc_we_i(frc_we_i),
  .frc_i   (frc_i),
  .busy_i  (busy_i),
  .pins_o  (pins_o),
  .status_o(status_o),
  .inv_i   (inv),
  .cs_i    (cs)
);

// File: tb/sim_cs_out_ctrl.sv
`timescale 1ns/1ps
module sim_cs_out_ctrl;

  localparam int NL = 8;
  localparam int CW = 2 * NL;
  localparam int NV = 13;

  // {cfg_we, cfg, frc_we, frc, busy, exp_status}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b1, 16'hFF00, 1'b0, 16'h00FF},
    {1'b0, 16'h0000, 1'b1, 16'h0005, 1'b0, 16'h00FA},
    {1'b0, 16'h0000, 1'b1, 16'h0102, 1'b0, 16'h00F9},
    {1'b0, 16'h0000, 1'b1, 16'h0404, 1'b0, 16'h00F9},
    {1'b1, 16'h0F03, 1'b0, 16'h0000, 1'b0, 16'h00FA},
    {1'b0, 16'h0000, 1'b1, 16'h0011, 1'b1, 16'h01EA},
    {1'b0, 16'h0000, 1'b1, 16'h0300, 1'b1, 16'h03EA},
    {1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h00E8},
    {1'b0, 16'h0000, 1'b1, 16'h0004, 1'b1, 16'h04E8},
    {1'b0, 16'h0000, 1'b1, 16'h0400, 1'b0, 16'h00EC},
    {1'b0, 16'h0000, 1'b1, 16'h0000, 1'b1, 16'h00EC},
    {1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h00EF},
    {1'b0, 16'h00FF, 1'b0, 16'h0000, 1'b0, 16'h00EF}
  };

  function automatic string vec_req(int i);
    case (i)
      0:         return "R6 all set";
      1, 2:      return "R4 set/clear";
      3:         return "R5 conflict";
      4:         return "R3 invert";
      5:         return "R7 defer cs";
      6:         return "R8 replace pending";
      7:         return "R8 release";
      8:         return "R9 pending flag";
      9:         return "R8 release-cycle write";
      10:        return "R5 empty command";
      default:   return "R2 config load";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0, frc_we = 1'b0, busy = 1'b0;
  logic [CW-1:0] cfg = '0, frc = '0;
  logic [NL-1:0] pins;
  logic [CW-1:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_out_ctrl #(.NUM_LINES(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_i(cfg),
    .frc_we_i(frc_we), .frc_i(frc), .busy_i(busy),
    .pins_o(pins), .status_o(status)
  );

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic cw, logic [CW-1:0] c, logic fw, logic [CW-1:0] f, logic b);
    cfg_we = cw; cfg = c; frc_we = fw; frc = f; busy = b;
  endtask

  initial begin
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset pins", {8'h00, pins}, 16'h0000);
    check("R1 reset status", status, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", status, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][50], VEC[i][49:34], VEC[i][33], VEC[i][32:17], VEC[i][16]);
      @(negedge clk);
      check(vec_req(i), {8'h00, pins}, {8'h00, VEC[i][7:0]});
      check(vec_req(i), status, VEC[i][15:0]);
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0);

    // R3: invert all lines, state EF -> pins 10
    drive(1'b1, 16'h00FF, 1'b0, '0, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R3 full invert", status, 16'h0010);

    // R1: reset mid-run clears state and configuration
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", status, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b0, '0, 1'b1, 16'hFF00, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R1 invert cleared by reset", status, 16'h00FF);

    // R7: plain line changes while busy, no pending recorded
    drive(1'b0, '0, 1'b1, 16'h0080, 1'b1);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R7 plain line while busy", status, 16'h007F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule